// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the memory operand address for a 16-bit processor that uses segments. Each request presents the two-bit mode field and the three-bit register/memory field of an instruction, along with a displacement word and a snapshot of the two base registers (BX, BP), the two index registers (SI, DI) and the four segment registers. An optional segment override may also be given. From these inputs the block forms a 16-bit offset, called the effective address. It picks a segment and combines the two into a 20-bit physical address.

A request is presented for one cycle with `req_valid` high. All results appear on registered outputs on the following clock edge, and `out_valid` is high for that one cycle. When the mode field names a register operand, the block reports it as a non-memory access and forms no address. The results stay unchanged until the next request.

Top module: `segaddr_gen`

## Requirements
- R1: For memory modes, the register/memory field picks the base and index terms as follows: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 6 = BP, 7 = BX.
- R2: The mode field picks the displacement term. Mode 0 adds no displacement. Mode 1 adds the low displacement byte, sign-extended to 16 bits. Mode 2 adds the full 16-bit displacement.
- R3: Mode 0 with register/memory field 6 is a direct address. The effective address is then the full displacement word, no register term is added, and the default segment is DS.
- R4: Mode 3 is a register operand. It gives `out_is_mem`=0, `out_ea`=0, `out_phys`=0 and `out_seg_sel`=3, whatever the override inputs hold.
- R5: The segment code is 0 = ES, 1 = CS, 2 = SS, 3 = DS. With no override, a memory mode whose base term is BP selects SS. Every other memory mode selects DS.
- R6: When `ovr_en` is high, a memory mode selects the segment given by `ovr_sel` in place of the default.
- R7: The effective address sum wraps modulo 65536. The physical address is (segment value × 16 + effective address) modulo 2^20.
- R8: `out_valid` is high exactly one cycle after a cycle with `req_valid` high. While `req_valid` is low, all result outputs hold their values.
- R9: A synchronous active-high reset clears `out_valid`, `out_is_mem`, `out_ea`, `out_seg_sel` and `out_phys` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| mod_f | input | 2 | Addressing mode field |
| rm_f | input | 3 | Register/memory field |
| disp | input | 16 | Displacement word (only the low byte is used in mode 1) |
| reg_bx | input | 16 | BX snapshot |
| reg_bp | input | 16 | BP snapshot |
| reg_si | input | 16 | SI snapshot |
| reg_di | input | 16 | DI snapshot |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_en | input | 1 | Segment override active |
| ovr_sel | input | 2 | Override segment code (0 ES, 1 CS, 2 SS, 3 DS) |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_is_mem | output | 1 | Operand is in memory |
| out_ea | output | 16 | Effective address |
| out_seg_sel | output | 2 | Selected segment code |
| out_phys | output | 20 | Physical address |

## Verification
The assertions check the following on every cycle: the one-cycle valid latency, that outputs hold while idle, the zeroed result for register mode, that the override wins, and the stack-segment default for BP-based modes. They also check that the low four bits of the physical address match the low four bits of the effective address. Only the bench scenarios can show that the offset sums are correct. These include all 24 memory mode and field pairs, sign extension of negative short displacements, the direct-address slot, and wrap-around of both the 16-bit and the 20-bit sums against values computed on their own.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_sel_e;

  typedef enum logic [1:0] {
    DSP_NONE  = 2'd0,
    DSP_SHORT = 2'd1,
    DSP_FULL  = 2'd2
  } disp_kind_e;

  localparam logic [1:0] MOD_NODISP = 2'b00;
  localparam logic [1:0] MOD_SHORT  = 2'b01;
  localparam logic [1:0] MOD_FULL   = 2'b10;
  localparam logic [1:0] MOD_REG    = 2'b11;
  localparam logic [2:0] RM_DIRECT  = 3'b110;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
(
  input  logic [1:0]  mod_i,
  input  logic [2:0]  rm_i,
  output logic        is_mem_o,
  output logic        use_bx_o,
  output logic        use_bp_o,
  output logic        use_si_o,
  output logic        use_di_o,
  output disp_kind_e  disp_kind_o
);
  always_comb begin
    use_bx_o    = 1'b0;
    use_bp_o    = 1'b0;
    use_si_o    = 1'b0;
    use_di_o    = 1'b0;
    disp_kind_o = DSP_NONE;
    is_mem_o    = (mod_i != MOD_REG);

    // base/index combination by register/memory field
    case (rm_i)
      3'd0: begin use_bx_o = 1'b1; use_si_o = 1'b1; end
      3'd1: begin use_bx_o = 1'b1; use_di_o = 1'b1; end
      3'd2: begin use_bp_o = 1'b1; use_si_o = 1'b1; end
      3'd3: begin use_bp_o = 1'b1; use_di_o = 1'b1; end
      3'd4: use_si_o = 1'b1;
      3'd5: use_di_o = 1'b1;
      3'd6: use_bp_o = 1'b1;
      default: use_bx_o = 1'b1;
    endcase

    case (mod_i)
      MOD_NODISP: begin
        if (rm_i == RM_DIRECT) begin
          // direct slot: displacement only, no BP
          use_bp_o    = 1'b0;
          disp_kind_o = DSP_FULL;
        end
      end
      MOD_SHORT: disp_kind_o = DSP_SHORT;
      MOD_FULL:  disp_kind_o = DSP_FULL;
      default: begin
        use_bx_o = 1'b0;
        use_bp_o = 1'b0;
        use_si_o = 1'b0;
        use_di_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              use_bx_i,
  input  logic              use_bp_i,
  input  logic              use_si_i,
  input  logic              use_di_i,
  input  disp_kind_e        disp_kind_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] bx_i,
  input  logic [ADDR_W-1:0] bp_i,
  input  logic [ADDR_W-1:0] si_i,
  input  logic [ADDR_W-1:0] di_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] index_term;
  logic [ADDR_W-1:0] disp_term;
  logic [ADDR_W-1:0] short_ext;

  assign short_ext = {{EXT_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};

  always_comb begin
    base_term  = ({ADDR_W{use_bx_i}} & bx_i) | ({ADDR_W{use_bp_i}} & bp_i);
    index_term = ({ADDR_W{use_si_i}} & si_i) | ({ADDR_W{use_di_i}} & di_i);
    case (disp_kind_i)
      DSP_SHORT: disp_term = short_ext;
      DSP_FULL:  disp_term = disp_i;
      default:   disp_term = '0;
    endcase
  end

  // modulo 2^ADDR_W by truncation
  assign ea_o = base_term + index_term + disp_term;
endmodule

// File: rtl/ea_seg_map.sv
module ea_seg_map
  import ea_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic              is_mem_i,
  input  logic              bp_base_i,
  input  logic              ovr_en_i,
  input  logic [1:0]        ovr_sel_i,
  input  logic [ADDR_W-1:0] es_i,
  input  logic [ADDR_W-1:0] cs_i,
  input  logic [ADDR_W-1:0] ss_i,
  input  logic [ADDR_W-1:0] ds_i,
  input  logic [ADDR_W-1:0] ea_i,
  output seg_sel_e          sel_o,
  output logic [ADDR_W+SEG_SHIFT-1:0] phys_o
);
  localparam int PHYS_W = ADDR_W + SEG_SHIFT;
  localparam int NSEG   = 4;

  logic [ADDR_W-1:0] seg_tab [NSEG];
  logic [ADDR_W-1:0] seg_val;

  assign seg_tab[0] = es_i;
  assign seg_tab[1] = cs_i;
  assign seg_tab[2] = ss_i;
  assign seg_tab[3] = ds_i;

  always_comb begin
    if (!is_mem_i)      sel_o = SEG_DS;
    else if (ovr_en_i)  sel_o = seg_sel_e'(ovr_sel_i);
    else if (bp_base_i) sel_o = SEG_SS;
    else                sel_o = SEG_DS;
  end

  assign seg_val = seg_tab[sel_o];

  // wraps modulo 2^PHYS_W
  assign phys_o = {seg_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea_i};

  logic [PHYS_W-1:0] unused_width_probe;
  assign unused_width_probe = phys_o;
endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SHORT_W   = 8,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = ADDR_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        mod_f,
  input  logic [2:0]        rm_f,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] reg_bx,
  input  logic [ADDR_W-1:0] reg_bp,
  input  logic [ADDR_W-1:0] reg_si,
  input  logic [ADDR_W-1:0] reg_di,
  input  logic [ADDR_W-1:0] seg_es,
  input  logic [ADDR_W-1:0] seg_cs,
  input  logic [ADDR_W-1:0] seg_ss,
  input  logic [ADDR_W-1:0] seg_ds,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_sel,
  output logic              out_valid,
  output logic              out_is_mem,
  output logic [ADDR_W-1:0] out_ea,
  output logic [1:0]        out_seg_sel,
  output logic [PHYS_W-1:0] out_phys
);
  logic              is_mem, use_bx, use_bp, use_si, use_di;
  disp_kind_e        disp_kind;
  logic [ADDR_W-1:0] ea_c;
  seg_sel_e          sel_c;
  logic [PHYS_W-1:0] phys_c;

  ea_mode_decode u_dec (
    .mod_i(mod_f), .rm_i(rm_f), .is_mem_o(is_mem),
    .use_bx_o(use_bx), .use_bp_o(use_bp), .use_si_o(use_si), .use_di_o(use_di),
    .disp_kind_o(disp_kind)
  );

  ea_offset_sum #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_sum (
    .use_bx_i(use_bx), .use_bp_i(use_bp), .use_si_i(use_si), .use_di_i(use_di),
    .disp_kind_i(disp_kind), .disp_i(disp),
    .bx_i(reg_bx), .bp_i(reg_bp), .si_i(reg_si), .di_i(reg_di),
    .ea_o(ea_c)
  );

  ea_seg_map #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_seg (
    .is_mem_i(is_mem), .bp_base_i(use_bp), .ovr_en_i(ovr_en), .ovr_sel_i(ovr_sel),
    .es_i(seg_es), .cs_i(seg_cs), .ss_i(seg_ss), .ds_i(seg_ds),
    .ea_i(ea_c), .sel_o(sel_c), .phys_o(phys_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_is_mem  <= 1'b0;
      out_ea      <= '0;
      out_seg_sel <= 2'd0;
      out_phys    <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_is_mem  <= is_mem;
        out_ea      <= is_mem ? ea_c : '0;
        out_seg_sel <= sel_c;
        out_phys    <= is_mem ? phys_c : '0;
      end
    end
  end

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && $stable(out_ea) && $stable(out_phys) && $stable(out_seg_sel)));

  // R4
  regmode_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mod_f == MOD_REG) |=> (!out_is_mem && out_ea == '0 && out_phys == '0
                                         && out_seg_sel == 2'd3));

  // R6
  override_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mod_f != MOD_REG && ovr_en) |=> (out_seg_sel == $past(ovr_sel)));

  // R5
  bp_stack_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ovr_en && mod_f != MOD_REG &&
     (rm_f == 3'd2 || rm_f == 3'd3 || (rm_f == RM_DIRECT && mod_f != MOD_NODISP)))
    |=> (out_seg_sel == 2'd2));

  // R7
  phys_low_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mod_f != MOD_REG) |=> (out_phys[SEG_SHIFT-1:0] == out_ea[SEG_SHIFT-1:0]));
endmodule

// File: tb/tb_segaddr_gen.sv
module tb_segaddr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  mod_f;
  logic [2:0]  rm_f;
  logic [15:0] disp, reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic        ovr_en;
  logic [1:0]  ovr_sel;
  logic        out_valid, out_is_mem;
  logic [15:0] out_ea;
  logic [1:0]  out_seg_sel;
  logic [19:0] out_phys;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  segaddr_gen dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mod_f(mod_f), .rm_f(rm_f),
    .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .out_valid(out_valid), .out_is_mem(out_is_mem), .out_ea(out_ea),
    .out_seg_sel(out_seg_sel), .out_phys(out_phys)
  );

  // {mod, rm, disp, ovr_en, ovr_sel}
  localparam logic [23:0] VEC [8] = '{
    {2'b00, 3'b110, 16'h2468, 1'b0, 2'b00},  // R3 direct, DS
    {2'b00, 3'b110, 16'h2468, 1'b1, 2'b00},  // R6 direct with ES
    {2'b01, 3'b110, 16'h00F9, 1'b0, 2'b00},  // R2 BP + negative byte, SS
    {2'b10, 3'b010, 16'h8001, 1'b1, 2'b11},  // R6 BP+SI forced to DS
    {2'b00, 3'b011, 16'h0000, 1'b1, 2'b01},  // R6 CS override
    {2'b11, 3'b011, 16'h1234, 1'b1, 2'b00},  // R4 register, override ignored
    {2'b01, 3'b000, 16'hFF80, 1'b0, 2'b00},  // R2 byte 0x80 sign extends
    {2'b10, 3'b111, 16'hFFFF, 1'b1, 2'b10}   // R7 offset wrap
  };

  function automatic logic [38:0] ref_calc(input logic [1:0] m, input logic [2:0] r,
                                           input logic [15:0] d, input logic oe,
                                           input logic [1:0] os);
    logic [15:0] base, idx, dsp, ea, sv;
    logic [1:0]  sel;
    logic [19:0] ph;
    logic        bpb;
    if (m == 2'b11) return {1'b0, 2'b11, 16'h0000, 20'h00000};
    bpb  = (r == 3'd2 || r == 3'd3 || r == 3'd6);
    base = (r == 3'd0 || r == 3'd1 || r == 3'd7) ? reg_bx : (bpb ? reg_bp : 16'h0000);
    idx  = (r == 3'd0 || r == 3'd2 || r == 3'd4) ? reg_si :
           ((r == 3'd1 || r == 3'd3 || r == 3'd5) ? reg_di : 16'h0000);
    dsp  = (m == 2'b01) ? {{8{d[7]}}, d[7:0]} : ((m == 2'b10) ? d : 16'h0000);
    if (m == 2'b00 && r == 3'd6) begin base = 16'h0000; bpb = 1'b0; dsp = d; end
    ea  = base + idx + dsp;
    sel = oe ? os : (bpb ? 2'b10 : 2'b11);
    sv  = (sel == 2'd0) ? seg_es : (sel == 2'd1) ? seg_cs : (sel == 2'd2) ? seg_ss : seg_ds;
    ph  = {sv, 4'h0} + {4'h0, ea};
    return {1'b1, sel, ea, ph};
  endfunction

  task automatic check(input string tag, input logic v_act, input logic v_exp,
                       input logic [38:0] act, input logic [38:0] exp);
    n_tests++;
    if (v_act !== v_exp || act !== exp) begin
      n_fail++;
      $display("FAIL %s: valid=%0b data=%h, expected valid=%0b data=%h",
               tag, v_act, act, v_exp, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [2:0] r, input logic [15:0] d,
                       input logic oe, input logic [1:0] os, input string tag);
    logic [38:0] exp;
    @(negedge clk);
    mod_f = m; rm_f = r; disp = d; ovr_en = oe; ovr_sel = os; req_valid = 1'b1;
    exp = ref_calc(m, r, d, oe, os);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, out_valid, 1'b1, {out_is_mem, out_seg_sel, out_ea, out_phys}, exp);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [38:0] held;
    rst = 1'b1; req_valid = 1'b1; mod_f = 2'b10; rm_f = 3'd0; disp = 16'h1234;
    reg_bx = 16'h1200; reg_bp = 16'h3400; reg_si = 16'h0056; reg_di = 16'h0078;
    seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000;
    ovr_en = 1'b0; ovr_sel = 2'd0;
    repeat (3) @(negedge clk);
    // R9 reset clears outputs even with a request pending
    check("R9", out_valid, 1'b0, {out_is_mem, out_seg_sel, out_ea, out_phys}, 39'h0);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R5: every memory mode against the model
    for (int m = 0; m < 3; m++) begin
      for (int r = 0; r < 8; r++) begin
        issue(m[1:0], r[2:0], 16'h1234, 1'b0, 2'd0, "R1/R2/R5 sweep");
      end
    end

    // table-driven scenarios
    for (int i = 0; i < 8; i++) begin
      issue(VEC[i][23:22], VEC[i][21:19], VEC[i][18:3], VEC[i][2], VEC[i][1:0],
            "R2/R3/R4/R6/R7 table");
    end

    // R3 hand value: direct 0x2468 in DS 0x4000
    issue(2'b00, 3'b110, 16'h2468, 1'b0, 2'd0, "R3 model");
    check("R3", out_valid, 1'b1, {out_is_mem, out_seg_sel, out_ea, out_phys},
          {1'b1, 2'b11, 16'h2468, 20'h42468});

    // R7 offset wrap: BX 0xFFFF + SI 0x0002
    reg_bx = 16'hFFFF; reg_si = 16'h0002;
    issue(2'b00, 3'b000, 16'h0000, 1'b0, 2'd0, "R7 model");
    check("R7", out_valid, 1'b1, {out_is_mem, out_seg_sel, out_ea, out_phys},
          {1'b1, 2'b11, 16'h0001, 20'h40001});

    // R7 physical wrap: DS 0xFFFF, direct 0x0020
    seg_ds = 16'hFFFF;
    issue(2'b00, 3'b110, 16'h0020, 1'b0, 2'd0, "R7 model");
    check("R7", out_valid, 1'b1, {out_is_mem, out_seg_sel, out_ea, out_phys},
          {1'b1, 2'b11, 16'h0020, 20'h00010});

    // R2 hand value: BP 0x3400 + byte 0xF9 -> 0x33F9 in SS
    issue(2'b01, 3'b110, 16'hABF9, 1'b0, 2'd0, "R2 model");
    check("R2", out_valid, 1'b1, {out_is_mem, out_seg_sel, out_ea, out_phys},
          {1'b1, 2'b10, 16'h33F9, 20'h333F9});

    // R8 hold while idle
    held = {out_is_mem, out_seg_sel, out_ea, out_phys};
    @(negedge clk);
    mod_f = 2'b11; reg_bp = 16'h0000; ovr_en = 1'b1; ovr_sel = 2'd1;
    @(negedge clk);
    @(negedge clk);
    check("R8", out_valid, 1'b0, {out_is_mem, out_seg_sel, out_ea, out_phys}, held);

    // R9 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", out_valid, 1'b0, {out_is_mem, out_seg_sel, out_ea, out_phys}, 39'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule